// File: doc/BRIEF.md
# Function Cycle Profiler

This block sits beside a processor's instruction fetch bus and works out how many fetch cycles the program spends inside each software function. It decodes every valid fetched instruction, and recognises two kinds: subroutine calls and subroutine returns. For a call, it forms the destination address and turns it into a small function number with a fixed hash in logic. It saves the caller's number on a hardware nesting stack and makes the callee current. For a return, it takes the caller's number back off the stack.

A single running counter measures the cycles spent in the current function since the last change of function. On every call or return, that count is added into a per-function total table, and the counter restarts at zero. A combinational read port returns any function's total by number. A clear input wipes the table between measurement runs. A sticky error flag reports an overflow or underflow of the nesting stack.

Top module: `fn_cycle_profiler`

## Requirements
- R1: After reset the current function number is 0, the error flag is 0, the running count is 0 and every stored total reads 0.
- R2: A valid fetch is a call when instruction bits [31:26] equal 6'h03. Its destination is the fetch PC plus the zero-extended value {instr[25:0], 2'b00}. A valid fetch is a return only when the whole word equals 32'h03E0_0008. Any other word, including one that differs from the return word only in bits [25:21], is an ordinary instruction.
- R3: The function number of a call destination d is computed as follows. First t = d + 32'h3A5C91E7. Then t = t + (t << 8). Then t = t ^ (t >> 4). Next b = (t >> 24) & 15 and a = (t + (t << 3)) >> 5. The number is the low 8 bits of a, XORed with byte b of the 128-bit table constant 128'h9D2E47B1_0C6AF3E8_5B1D92C4_7EA0368F. Byte 0 of that constant is its least significant byte.
- R4: A call made while the stack holds fewer than 32 entries pushes the current number onto the stack. The hashed destination number then becomes current.
- R5: A return made while the stack is not empty makes the most recently pushed number current again and removes it from the stack.
- R6: Every valid fetch is charged to the function that is current when it is fetched. This includes the fetch of the call or return itself. On a call or return, the stored total of the function being left grows by the running count plus one, and the running count returns to 0. Cycles with the valid strobe low are not charged.
- R7: A call made while the stack holds 32 entries sets the error flag. It leaves the stack and the current function unchanged, and its cycle is still charged as in R6.
- R8: A return made while the stack is empty sets the error flag and leaves the current function unchanged.
- R9: Once set, the error flag stays at 1 until reset.
- R10: A cycle with clear high sets every stored total and the running count to 0. Clear takes priority over any update in the same cycle.
- R11: The read port returns the stored total of the requested function number in the same cycle. The total reflects all events registered up to the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch is present this cycle |
| fetch_pc | input | 32 | Address of the fetched instruction |
| fetch_instr | input | 32 | Fetched instruction word |
| clear | input | 1 | Zero all stored totals and the running count |
| rd_idx | input | 8 | Function number to read |
| rd_total | output | 32 | Stored total of function rd_idx |
| cur_fn | output | 8 | Number of the function currently executing |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The bench nests calls two deep and returns. It checks that the call and return fetches are charged to the function being left. A design that charges the event to the new function, or drops the event cycle, ends every total off by one. It drives gaps with the valid strobe low, and a word that differs from the return encoding only in the register field. A careless decoder would miscount the gaps or pop the stack on that near-return. It also pushes past 32 levels and pops an empty stack. A design whose pointer wraps would overwrite the caller chain or return to a stale number, and the bench then sees the wrong current function when it unwinds.

// File: rtl/fn_cycle_profiler.sv
`timescale 1ns/1ps
module fn_cycle_profiler #(
  parameter int FN_W  = 8,
  parameter int DEPTH = 32,
  parameter int CNT_W = 32,
  parameter logic [31:0] V1 = 32'h3A5C91E7,
  parameter int A1 = 3,
  parameter int A2 = 5,
  parameter int B1 = 24,
  parameter int B2 = 15,
  parameter logic [(B2+1)*FN_W-1:0] TAB = 128'h9D2E47B1_0C6AF3E8_5B1D92C4_7EA0368F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [31:0]      fetch_pc,
  input  logic [31:0]      fetch_instr,
  input  logic             clear,
  input  logic [FN_W-1:0]  rd_idx,
  output logic [CNT_W-1:0] rd_total,
  output logic [FN_W-1:0]  cur_fn,
  output logic             stk_err
);
  localparam int NFN   = 1 << FN_W;
  localparam int TAB_N = B2 + 1;
  localparam int TB_W  = (TAB_N > 1) ? $clog2(TAB_N) : 1;
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int SI_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [5:0]  OP_CALL  = 6'h03;
  localparam logic [31:0] RET_WORD = {6'h00, 5'd31, 15'd0, 6'h08};

  logic [FN_W-1:0]  tab_w [TAB_N];
  logic [FN_W-1:0]  stk   [DEPTH];
  logic [CNT_W-1:0] store [NFN];
  logic [SP_W-1:0]  sp;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      tgt, t0, t1, t2, av;
  logic [TB_W-1:0]  bsel;
  logic [FN_W-1:0]  hidx, top;

  for (genvar i = 0; i < TAB_N; i++) begin : g_tab
    assign tab_w[i] = TAB[i*FN_W +: FN_W];
  end

  wire is_call = fetch_valid && (fetch_instr[31:26] == OP_CALL);
  wire is_ret  = fetch_valid && (fetch_instr == RET_WORD);
  wire evt     = is_call || is_ret;
  wire full    = (sp == SP_W'(DEPTH));
  wire empty   = (sp == '0);
  wire push_ok = is_call && !full;
  wire pop_ok  = is_ret && !empty;

  assign tgt  = fetch_pc + {4'd0, fetch_instr[25:0], 2'b00};
  assign t0   = tgt + V1;
  assign t1   = t0 + (t0 << 8);
  assign t2   = t1 ^ (t1 >> 4);
  assign bsel = TB_W'((t2 >> B1) & B2);
  assign av   = (t2 + (t2 << A1)) >> A2;
  assign hidx = FN_W'(av) ^ tab_w[bsel];
  assign top  = stk[SI_W'(sp - SP_W'(1))];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp      <= '0;
      cur_fn  <= '0;
      stk_err <= 1'b0;
    end else begin
      if (push_ok) begin
        sp     <= sp + SP_W'(1);
        cur_fn <= hidx;
      end else if (pop_ok) begin
        sp     <= sp - SP_W'(1);
        cur_fn <= top;
      end
      if ((is_call && full) || (is_ret && empty))
        stk_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok)
      stk[SI_W'(sp)] <= cur_fn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      cnt <= '0;
    else if (evt)
      cnt <= '0;
    else if (fetch_valid)
      cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int i = 0; i < NFN; i++) store[i] <= '0;
    end else if (evt) begin
      store[cur_fn] <= store[cur_fn] + cnt + CNT_W'(1);
    end
  end

  assign rd_total = store[rd_idx];

  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) sp <= SP_W'(DEPTH)); // R7
  AST_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (sp == $past(sp) + SP_W'(1)) && (cur_fn == $past(hidx))); // R4
  AST_POP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (sp == $past(sp) - SP_W'(1)) && (cur_fn == $past(top))); // R5
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_call && full) |=> (sp == $past(sp)) && (cur_fn == $past(cur_fn)) && stk_err); // R7
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ret && empty) |=> (sp == '0) && (cur_fn == $past(cur_fn)) && stk_err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err); // R9
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (cnt == '0)); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !evt && !clear) |=> (cnt == $past(cnt) + CNT_W'(1))); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !clear) |=> $stable(cnt)); // R6
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0) && (store[0] == '0)); // R10
endmodule

// File: tb/tb_fn_cycle_profiler.sv
`timescale 1ns/1ps
module tb_fn_cycle_profiler;
  localparam int DEPTH = 32;
  localparam logic [31:0]  RET_WORD = 32'h03E0_0008;
  localparam logic [127:0] TABC = 128'h9D2E47B1_0C6AF3E8_5B1D92C4_7EA0368F;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, fetch_valid = 1'b0, clear = 1'b0;
  logic [31:0] fetch_pc = '0, fetch_instr = '0;
  logic [7:0]  rd_idx = '0;
  logic [31:0] rd_total;
  logic [7:0]  cur_fn;
  logic        stk_err;

  fn_cycle_profiler dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_instr(fetch_instr), .clear(clear), .rd_idx(rd_idx),
    .rd_total(rd_total), .cur_fn(cur_fn), .stk_err(stk_err)
  );

  typedef struct {int kind; logic [31:0] exp; string tag;} item_t;
  item_t q[$];
  item_t it;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_store [256];
  logic [31:0] m_cnt;
  logic [7:0]  m_cur;
  logic [7:0]  m_stk[$];
  bit          m_err;

  function automatic logic [7:0] hash(input logic [31:0] d);
    logic [31:0] t, a;
    int b;
    t = d + 32'h3A5C91E7;
    t = t + (t << 8);
    t = t ^ (t >> 4);
    b = int'((t >> 24) & 32'd15);
    a = (t + (t << 3)) >> 5;
    return a[7:0] ^ TABC[b*8 +: 8];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_store[i] = '0;
    m_cnt = '0; m_cur = '0; m_err = 0; m_stk.delete();
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; fetch_valid = 0; clear = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    model_reset();
  endtask

  task automatic fetch(input logic [31:0] pc, input logic [31:0] instr);
    logic [31:0] d;
    @(posedge clk); #1;
    fetch_valid = 1; clear = 0; fetch_pc = pc; fetch_instr = instr;
    if (instr[31:26] == 6'h03 || instr == RET_WORD) begin
      m_store[m_cur] = m_store[m_cur] + m_cnt + 1;
      m_cnt = 0;
      if (instr[31:26] == 6'h03) begin
        d = pc + {4'd0, instr[25:0], 2'b00};
        if (m_stk.size() == DEPTH) m_err = 1;
        else begin m_stk.push_back(m_cur); m_cur = hash(d); end
      end else begin
        if (m_stk.size() == 0) m_err = 1;
        else m_cur = m_stk.pop_back();
      end
    end else m_cnt = m_cnt + 1;
  endtask

  task automatic plain(input int n);
    for (int i = 0; i < n; i++) fetch(32'h100 + 4*i, 32'h0000_0020);
  endtask

  task automatic call_to(input logic [31:0] pc, input logic [31:0] d);
    logic [31:0] off;
    off = (d - pc) >> 2;
    fetch(pc, {6'h03, off[25:0]});
  endtask

  task automatic ret_now();
    fetch(32'h200, RET_WORD);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1 fetch_valid = 0; clear = 0; end
  endtask

  task automatic do_clear();
    @(posedge clk); #1 fetch_valid = 0; clear = 1;
    for (int i = 0; i < 256; i++) m_store[i] = '0;
    m_cnt = 0;
  endtask

  task automatic exp_total(input logic [7:0] idx, input string tag);
    @(posedge clk); #1 fetch_valid = 0; clear = 0; rd_idx = idx;
    q.push_back('{0, m_store[idx], tag});
  endtask

  task automatic exp_cur(input string tag);
    @(posedge clk); #1 fetch_valid = 0; clear = 0;
    q.push_back('{1, {24'd0, m_cur}, tag});
  endtask

  task automatic exp_err(input string tag);
    @(posedge clk); #1 fetch_valid = 0; clear = 0;
    q.push_back('{2, {31'd0, m_err}, tag});
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      logic [31:0] got;
      it = q.pop_front();
      got = (it.kind == 0) ? rd_total : (it.kind == 1) ? {24'd0, cur_fn} : {31'd0, stk_err};
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.tag, it.kind, got, it.exp);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ha, hb;
    model_reset();
    do_reset();
    exp_cur("R1 cur after reset");
    exp_err("R1 err after reset");
    exp_total(8'd0, "R1 total0 after reset");
    exp_total(hash(32'h0000_4000), "R1 other total after reset");

    plain(3); idle(2); plain(2);
    call_to(32'h0000_0400, 32'h0000_4000);
    ha = hash(32'h0000_4000);
    exp_cur("R3 hashed call number");
    exp_total(8'd0, "R6 caller charged incl call, gaps skipped");
    plain(3);
    call_to(32'h0000_4010, 32'h0001_2340);
    hb = hash(32'h0001_2340);
    exp_cur("R4 nested call current");
    plain(2);
    ret_now();
    exp_cur("R5 return restores caller");
    exp_total(hb, "R6 callee total");
    exp_total(ha, "R11 read port total A");
    fetch(32'h210, 32'h03E5_0008);
    exp_cur("R2 near-return word ignored");
    plain(1);
    ret_now();
    exp_cur("R5 back to root");
    exp_total(ha, "R6 A total after second segment");
    fetch(32'h300, 32'h0FFF_FFFF);
    exp_cur("R2 call opcode with far offset");
    ret_now();
    exp_total(8'd0, "R6 root total");

    plain(4);
    do_clear();
    exp_total(8'd0, "R10 total cleared");
    exp_total(ha, "R10 other total cleared");
    plain(2);
    call_to(32'h0000_0800, 32'h0000_9000);
    exp_total(8'd0, "R10 count restarted after clear");

    for (int i = 0; i < DEPTH + 2; i++) begin
      call_to(32'h0000_1000, 32'h0010_0000 + 32'h40 * i);
      plain(1);
    end
    exp_err("R7 overflow sets error");
    exp_cur("R7 current unchanged on overflow");
    for (int i = 0; i < DEPTH; i++) ret_now();
    exp_cur("R7 stack intact after overflow");
    exp_total(hash(32'h0010_0000), "R6 deep function total");

    do_reset();
    exp_err("R1 err cleared by reset");
    plain(2);
    ret_now();
    exp_err("R8 underflow sets error");
    exp_cur("R8 current unchanged on underflow");
    exp_total(8'd0, "R6 underflow cycle charged");
    plain(3);
    call_to(32'h0000_0400, 32'h0000_4000);
    ret_now();
    exp_err("R9 error stays set");
    exp_cur("R5 return after underflow");

    idle(3);
    wait (q.size() == 0);
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule